// File: doc/BRIEF.md
# Tagged Result FIFO with Threshold Interrupt

This block buffers conversion results coming out of a data converter engine. Every entry holds the result word together with the number of the channel it came from, so software reading the queue always knows which input a value belongs to. The engine pushes through a write strobe and the CPU pops through a read strobe. Each read returns the oldest entry one clock later, along with a valid marker.

Software programs a 4-bit stage count N. When a write brings the number of stored entries up to N+1, a sticky threshold flag is raised. The flag holds until software clears it, and it can be raised again by later fills. The interrupt output is the flag gated by an enable bit. Two more status bits are provided. The empty bit reads 1 after reset and after a clear. The overrun bit records a write that had no room, and it stays set until software clears it.

The depth is a parameter. A scan queue uses 16 entries and a priority queue uses 4. A single clear strobe empties the queue.

Top module: `tagged_result_fifo`

## Requirements
- R1: The queue holds exactly DEPTH entries (16 by default; 4 in the priority configuration), and the stored count never exceeds DEPTH.
- R2: While reset is asserted and after it is released, empty is 1 and thr_flag, overrun, irq and rd_valid are 0.
- R3: An accepted write stores wr_result and wr_chan as one entry. The write that follows an empty state drives empty to 0 from the next cycle.
- R4: A read of a non-empty queue returns the oldest entry on rd_result/rd_chan with rd_valid=1 in the cycle after rd_en. Entries come out in write order, and a read and a write in the same cycle are both performed.
- R5: A read of an empty queue sets rd_valid=0 and rd_result=0, rd_chan=0 in the next cycle and leaves the read position unchanged.
- R6: thr_flag is set when an accepted write brings the stored count from N to N+1, where N is stage_n. For example, N=15 raises the flag on the 16th entry and not on the 15th.
- R7: thr_flag stays at 1 until a flag_clr pulse. A set in the same cycle takes priority over the clear, and the flag can rise again on a later fill.
- R8: A write to a full queue without a same-cycle read is dropped, leaving the contents unchanged, and sets overrun. A write with a same-cycle read on a full queue is accepted.
- R9: overrun stays at 1 until an ovr_clr pulse or a fifo_clr pulse.
- R10: irq is 1 only when thr_flag is 1 and irq_en is 1.
- R11: fifo_clr empties the queue (empty=1 next cycle), clears overrun and leaves thr_flag unchanged. It overrides a same-cycle write or read, and a read that coincides with it returns rd_valid=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe from the conversion engine |
| wr_result | input | RESULT_W | Result word to store |
| wr_chan | input | CHAN_W | Channel number stored with the result |
| rd_en | input | 1 | Read strobe from the CPU |
| rd_result | output | RESULT_W | Result of the last read (0 if invalid) |
| rd_chan | output | CHAN_W | Channel of the last read (0 if invalid) |
| rd_valid | output | 1 | 1 if the last read returned an entry |
| fifo_clr | input | 1 | Empties the queue and clears overrun |
| ovr_clr | input | 1 | Clears the overrun bit |
| flag_clr | input | 1 | Clears the threshold flag |
| stage_n | input | 4 | Threshold setting N; the flag rises at N+1 entries |
| irq_en | input | 1 | Interrupt enable |
| empty | output | 1 | 1 when no entries are stored |
| overrun | output | 1 | Sticky record of a dropped write |
| thr_flag | output | 1 | Sticky threshold flag |
| irq | output | 1 | Interrupt request |

## Verification
The bound checker checks the following on every cycle:
- The count stays bounded.
- The flag and the overrun bit are sticky.
- A write into an empty queue clears empty.
- A write into a full queue with no read raises overrun.
- An empty read gives an invalid result.
- The clear strobe empties the queue.
- irq is never raised without its enable.

Only the bench scenarios can show the data itself:
- entries come back in write order with the correct channel tags;
- a dropped write really leaves the contents untouched;
- the flag rises on exactly the N+1th entry for several settings of N;
- a 4-entry configuration fills and overruns at its own depth.

// File: rtl/tfifo_pkg.sv
package tfifo_pkg;
  localparam int DEF_DEPTH    = 16;
  localparam int DEF_RESULT_W = 12;
  localparam int DEF_CHAN_W   = 5;
  localparam int STAGE_W      = 4;
endpackage

// File: rtl/tfifo_ptrs.sv
module tfifo_ptrs #(
  parameter int DEPTH = 16,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic             clr,
  output logic             wr_ok,
  output logic             rd_ok,
  output logic             ovr_req,
  output logic [PTR_W-1:0] wptr,
  output logic [PTR_W-1:0] rptr,
  output logic [CNT_W-1:0] count_q,
  output logic [CNT_W-1:0] count_d
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [PTR_W-1:0] wptr_d, rptr_d;
  logic             is_full, is_empty;

  assign is_full  = (count_q == FULL);
  assign is_empty = (count_q == '0);

  always_comb begin
    rd_ok   = rd_en && !clr && !is_empty;
    wr_ok   = wr_en && !clr && (!is_full || rd_ok);
    ovr_req = wr_en && !clr && !wr_ok;
    wptr_d  = wptr;
    rptr_d  = rptr;
    count_d = count_q;
    if (clr) begin
      wptr_d  = '0;
      rptr_d  = '0;
      count_d = '0;
    end else begin
      if (wr_ok) wptr_d = (wptr == LAST) ? '0 : wptr + 1'b1;
      if (rd_ok) rptr_d = (rptr == LAST) ? '0 : rptr + 1'b1;
      count_d = count_q + CNT_W'(wr_ok) - CNT_W'(rd_ok);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr    <= '0;
      rptr    <= '0;
      count_q <= '0;
    end else begin
      wptr    <= wptr_d;
      rptr    <= rptr_d;
      count_q <= count_d;
    end
  end
endmodule

// File: rtl/tfifo_store.sv
module tfifo_store #(
  parameter int DEPTH   = 16,
  parameter int ENTRY_W = 17,
  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_ok,
  input  logic [PTR_W-1:0]   wptr,
  input  logic [ENTRY_W-1:0] wr_entry,
  input  logic               rd_en,
  input  logic               rd_ok,
  input  logic [PTR_W-1:0]   rptr,
  output logic [ENTRY_W-1:0] rd_entry,
  output logic               rd_valid
);
  logic [ENTRY_W-1:0] slot [DEPTH];
  logic [ENTRY_W-1:0] rd_entry_d;
  logic               rd_valid_d;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic slot_en;
    assign slot_en = wr_ok && (wptr == PTR_W'(g));
    always_ff @(posedge clk) begin
      if (slot_en) slot[g] <= wr_entry;
    end
  end

  always_comb begin
    rd_entry_d = rd_entry;
    rd_valid_d = rd_valid;
    if (rd_en) begin
      rd_valid_d = rd_ok;
      rd_entry_d = rd_ok ? slot[rptr] : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_entry <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_entry <= rd_entry_d;
      rd_valid <= rd_valid_d;
    end
  end
endmodule

// File: rtl/tfifo_flags.sv
module tfifo_flags #(
  parameter int CNT_W   = 5,
  parameter int STAGE_W = 4,
  localparam int CMP_W  = (CNT_W > STAGE_W + 1) ? CNT_W : STAGE_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_ok,
  input  logic               ovr_req,
  input  logic               clr,
  input  logic [CNT_W-1:0]   count_q,
  input  logic [CNT_W-1:0]   count_d,
  input  logic [STAGE_W-1:0] stage_n,
  input  logic               flag_clr,
  input  logic               ovr_clr,
  output logic               thr_flag,
  output logic               overrun
);
  logic [CMP_W-1:0] thr;
  logic             hit;
  logic             flag_d, ovr_d;

  always_comb begin
    thr = CMP_W'(stage_n) + 1'b1;
    hit = wr_ok && (CMP_W'(count_d) == thr) && (CMP_W'(count_q) != thr);
    flag_d = thr_flag;
    if (hit)           flag_d = 1'b1;
    else if (flag_clr) flag_d = 1'b0;
    ovr_d = overrun;
    if (ovr_req)              ovr_d = 1'b1;
    else if (ovr_clr || clr)  ovr_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_flag <= 1'b0;
      overrun  <= 1'b0;
    end else begin
      thr_flag <= flag_d;
      overrun  <= ovr_d;
    end
  end
endmodule

// File: rtl/tagged_result_fifo.sv
module tagged_result_fifo
  import tfifo_pkg::*;
#(
  parameter int DEPTH    = DEF_DEPTH,
  parameter int RESULT_W = DEF_RESULT_W,
  parameter int CHAN_W   = DEF_CHAN_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [RESULT_W-1:0] wr_result,
  input  logic [CHAN_W-1:0]   wr_chan,
  input  logic                rd_en,
  output logic [RESULT_W-1:0] rd_result,
  output logic [CHAN_W-1:0]   rd_chan,
  output logic                rd_valid,
  input  logic                fifo_clr,
  input  logic                ovr_clr,
  input  logic                flag_clr,
  input  logic [STAGE_W-1:0]  stage_n,
  input  logic                irq_en,
  output logic                empty,
  output logic                overrun,
  output logic                thr_flag,
  output logic                irq
);
  localparam int ENTRY_W = RESULT_W + CHAN_W;
  localparam int PTR_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W   = $clog2(DEPTH + 1);

  logic [1:0]         rst_pipe;
  logic               rst_sync_n;
  logic               wr_ok, rd_ok, ovr_req;
  logic [PTR_W-1:0]   wptr, rptr;
  logic [CNT_W-1:0]   count_q, count_d;
  logic [ENTRY_W-1:0] rd_entry;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  tfifo_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .rd_en(rd_en),
    .clr(fifo_clr), .wr_ok(wr_ok), .rd_ok(rd_ok), .ovr_req(ovr_req),
    .wptr(wptr), .rptr(rptr), .count_q(count_q), .count_d(count_d)
  );

  tfifo_store #(.DEPTH(DEPTH), .ENTRY_W(ENTRY_W)) u_store (
    .clk(clk), .rst_n(rst_sync_n), .wr_ok(wr_ok), .wptr(wptr),
    .wr_entry({wr_chan, wr_result}), .rd_en(rd_en), .rd_ok(rd_ok),
    .rptr(rptr), .rd_entry(rd_entry), .rd_valid(rd_valid)
  );

  tfifo_flags #(.CNT_W(CNT_W), .STAGE_W(STAGE_W)) u_flags (
    .clk(clk), .rst_n(rst_sync_n), .wr_ok(wr_ok), .ovr_req(ovr_req),
    .clr(fifo_clr), .count_q(count_q), .count_d(count_d),
    .stage_n(stage_n), .flag_clr(flag_clr), .ovr_clr(ovr_clr),
    .thr_flag(thr_flag), .overrun(overrun)
  );

  assign rd_result = rd_entry[RESULT_W-1:0];
  assign rd_chan   = rd_entry[ENTRY_W-1:RESULT_W];
  assign empty     = (count_q == '0);
  assign irq       = thr_flag & irq_en;
endmodule

// File: rtl/tfifo_checker.sv
module tfifo_checker #(
  parameter int DEPTH = 16,
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst_sync_n,
  input logic             wr_en,
  input logic             rd_en,
  input logic             fifo_clr,
  input logic             ovr_clr,
  input logic             flag_clr,
  input logic             irq_en,
  input logic             empty,
  input logic             overrun,
  input logic             thr_flag,
  input logic             irq,
  input logic             rd_valid,
  input logic [CNT_W-1:0] count_q
);
  // R1: the count is bounded by the depth
  p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    count_q <= CNT_W'(DEPTH));

  // R3: a write into an empty queue clears empty
  p_first_write_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (empty && wr_en && !fifo_clr) |=> !empty);

  // R5: a read of an empty queue gives an invalid result
  p_empty_read_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (empty && rd_en && !fifo_clr) |=> !rd_valid);

  // R7: the flag holds until cleared
  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (thr_flag && !flag_clr) |=> thr_flag);

  // R8: a write to a full queue with no read raises overrun
  p_full_write_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (count_q == CNT_W'(DEPTH) && wr_en && !rd_en && !fifo_clr) |=> overrun);

  // R9: overrun holds until cleared
  p_ovr_sticky_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (overrun && !ovr_clr && !fifo_clr) |=> overrun);

  // R10: no interrupt without enable
  p_irq_gate_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq |-> (irq_en && thr_flag));

  // R11: clear empties the queue and drops overrun
  p_clear_r11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    fifo_clr |=> (empty && !overrun));
endmodule

bind tagged_result_fifo tfifo_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .wr_en(wr_en), .rd_en(rd_en),
  .fifo_clr(fifo_clr), .ovr_clr(ovr_clr), .flag_clr(flag_clr),
  .irq_en(irq_en), .empty(empty), .overrun(overrun), .thr_flag(thr_flag),
  .irq(irq), .rd_valid(rd_valid), .count_q(count_q)
);

// File: tb/tb_tagged_result_fifo.sv
module tb_tagged_result_fifo;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n;
  logic        wr_en, rd_en, fifo_clr, ovr_clr, flag_clr, irq_en;
  logic [11:0] wr_result, rd_result;
  logic [4:0]  wr_chan, rd_chan;
  logic [3:0]  stage_n;
  logic        rd_valid, empty, overrun, thr_flag, irq;

  logic        p_wr, p_rd;
  logic [11:0] p_res_in, p_res;
  logic [4:0]  p_chan_in, p_chan;
  logic        p_valid, p_empty, p_ovr, p_flag, p_irq;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  tagged_result_fifo dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_result(wr_result),
    .wr_chan(wr_chan), .rd_en(rd_en), .rd_result(rd_result),
    .rd_chan(rd_chan), .rd_valid(rd_valid), .fifo_clr(fifo_clr),
    .ovr_clr(ovr_clr), .flag_clr(flag_clr), .stage_n(stage_n),
    .irq_en(irq_en), .empty(empty), .overrun(overrun),
    .thr_flag(thr_flag), .irq(irq)
  );

  tagged_result_fifo #(.DEPTH(4)) dut_pri (
    .clk(clk), .rst_n(rst_n), .wr_en(p_wr), .wr_result(p_res_in),
    .wr_chan(p_chan_in), .rd_en(p_rd), .rd_result(p_res),
    .rd_chan(p_chan), .rd_valid(p_valid), .fifo_clr(1'b0),
    .ovr_clr(1'b0), .flag_clr(1'b0), .stage_n(4'd3),
    .irq_en(1'b1), .empty(p_empty), .overrun(p_ovr),
    .thr_flag(p_flag), .irq(p_irq)
  );

  typedef struct packed {
    logic        wr;
    logic        rd;
    logic [11:0] d;
    logic [4:0]  t;
    logic        e_empty;
    logic        e_flag;
    logic        chk_rd;
    logic        e_valid;
    logic [11:0] e_d;
    logic [4:0]  e_t;
  } vec_t;

  // stage_n = 2: the flag rises on the third stored entry
  localparam vec_t VECS [10] = '{
    '{1'b1, 1'b0, 12'h123, 5'd3,  1'b0, 1'b0, 1'b0, 1'b0, 12'h000, 5'd0},
    '{1'b1, 1'b0, 12'h456, 5'd7,  1'b0, 1'b0, 1'b0, 1'b0, 12'h000, 5'd0},
    '{1'b1, 1'b0, 12'h789, 5'd1,  1'b0, 1'b1, 1'b0, 1'b0, 12'h000, 5'd0},
    '{1'b0, 1'b1, 12'h000, 5'd0,  1'b0, 1'b1, 1'b1, 1'b1, 12'h123, 5'd3},
    '{1'b1, 1'b1, 12'hABC, 5'd12, 1'b0, 1'b1, 1'b1, 1'b1, 12'h456, 5'd7},
    '{1'b0, 1'b1, 12'h000, 5'd0,  1'b0, 1'b1, 1'b1, 1'b1, 12'h789, 5'd1},
    '{1'b0, 1'b1, 12'h000, 5'd0,  1'b1, 1'b1, 1'b1, 1'b1, 12'hABC, 5'd12},
    '{1'b0, 1'b1, 12'h000, 5'd0,  1'b1, 1'b1, 1'b1, 1'b0, 12'h000, 5'd0},
    '{1'b1, 1'b0, 12'h0FF, 5'd31, 1'b0, 1'b1, 1'b0, 1'b0, 12'h000, 5'd0},
    '{1'b0, 1'b1, 12'h000, 5'd0,  1'b1, 1'b1, 1'b1, 1'b1, 12'h0FF, 5'd31}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive one cycle of strobes at a falling edge, return at the next falling edge
  task automatic cyc(input logic w, input logic r, input logic [11:0] d, input logic [4:0] t,
                     input logic fc, input logic oc, input logic fl);
    wr_en = w; rd_en = r; wr_result = d; wr_chan = t;
    fifo_clr = fc; ovr_clr = oc; flag_clr = fl;
    @(negedge clk);
    wr_en = 0; rd_en = 0; fifo_clr = 0; ovr_clr = 0; flag_clr = 0;
  endtask

  task automatic pcyc(input logic w, input logic r, input logic [11:0] d, input logic [4:0] t);
    p_wr = w; p_rd = r; p_res_in = d; p_chan_in = t;
    @(negedge clk);
    p_wr = 0; p_rd = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 0;
    wr_en = 0; rd_en = 0; fifo_clr = 0; ovr_clr = 0; flag_clr = 0;
    wr_result = 0; wr_chan = 0; stage_n = 4'd2; irq_en = 1;
    p_wr = 0; p_rd = 0; p_res_in = 0; p_chan_in = 0;
    repeat (3) @(negedge clk);
    // R2: state during reset
    check("R2 empty in reset", empty, 1);
    check("R2 flag in reset", thr_flag, 0);
    check("R2 overrun in reset", overrun, 0);
    check("R2 irq in reset", irq, 0);
    check("R2 rd_valid in reset", rd_valid, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check("R2 empty after reset", empty, 1);
    check("R2 flag after reset", thr_flag, 0);

    // table walk: R3 R4 R5 R6
    for (int i = 0; i < 10; i++) begin
      cyc(VECS[i].wr, VECS[i].rd, VECS[i].d, VECS[i].t, 0, 0, 0);
      check($sformatf("R3 empty vec %0d", i), empty, VECS[i].e_empty);
      check($sformatf("R6 flag vec %0d", i), thr_flag, VECS[i].e_flag);
      if (VECS[i].chk_rd) begin
        check($sformatf("R4/R5 valid vec %0d", i), rd_valid, VECS[i].e_valid);
        check($sformatf("R4/R5 result vec %0d", i), rd_result, VECS[i].e_d);
        check($sformatf("R4/R5 chan vec %0d", i), rd_chan, VECS[i].e_t);
      end
    end

    // R10: interrupt gating
    check("R10 irq with enable", irq, 1);
    irq_en = 0; #1;
    check("R10 irq masked", irq, 0);
    irq_en = 1; #1;

    // R7: clear and re-fire
    cyc(0, 0, 0, 0, 0, 0, 1);
    check("R7 flag cleared", thr_flag, 0);
    check("R10 irq follows flag", irq, 0);
    for (int i = 0; i < 2; i++) cyc(1, 0, 12'(i), 5'(i), 0, 0, 0);
    check("R7 flag stays clear below threshold", thr_flag, 0);
    cyc(1, 0, 12'h2, 5'd2, 0, 0, 0);
    check("R7 flag fires again", thr_flag, 1);

    // R11: clear
    cyc(0, 0, 0, 0, 1, 0, 0);
    check("R11 empty after clear", empty, 1);
    check("R11 flag kept by clear", thr_flag, 1);
    cyc(1, 0, 12'h333, 5'd9, 1, 0, 0);
    check("R11 clear beats write", empty, 1);
    cyc(0, 1, 0, 0, 0, 0, 0);
    check("R11 nothing left after clear", rd_valid, 0);

    // R6 with N=15, R1 full depth
    cyc(0, 0, 0, 0, 0, 0, 1);
    stage_n = 4'd15;
    for (int i = 0; i < 15; i++) cyc(1, 0, 12'(i * 5 + 1), 5'(i), 0, 0, 0);
    check("R6 no flag at 15 entries", thr_flag, 0);
    cyc(1, 0, 12'(15 * 5 + 1), 5'd15, 0, 0, 0);
    check("R6 flag at 16 entries", thr_flag, 1);
    check("R8 no overrun at full", overrun, 0);
    cyc(1, 0, 12'hEEE, 5'd30, 0, 0, 0);
    check("R8 overrun on full write", overrun, 1);
    cyc(0, 0, 0, 0, 0, 0, 0);
    check("R9 overrun sticky", overrun, 1);
    cyc(0, 0, 0, 0, 0, 1, 0);
    check("R9 overrun cleared", overrun, 0);
    cyc(1, 1, 12'h555, 5'd20, 0, 0, 0);
    check("R8 read+write at full no overrun", overrun, 0);
    check("R4 oldest out at full", rd_result, 12'(1));
    check("R4 oldest chan", rd_chan, 0);
    for (int i = 1; i < 16; i++) begin
      cyc(0, 1, 0, 0, 0, 0, 0);
      check($sformatf("R4 order result %0d", i), rd_result, 12'(i * 5 + 1));
      check($sformatf("R4 order chan %0d", i), rd_chan, 5'(i));
    end
    cyc(0, 1, 0, 0, 0, 0, 0);
    check("R8 accepted write at full", rd_result, 12'h555);
    check("R8 accepted write chan", rd_chan, 5'd20);
    check("R1 drained", empty, 1);
    cyc(0, 1, 0, 0, 0, 0, 0);
    check("R8 dropped write absent", rd_valid, 0);

    // R1: 4-entry configuration
    for (int i = 0; i < 4; i++) pcyc(1, 0, 12'(100 + i), 5'(i + 8));
    check("R1 pri flag at 4 entries", p_flag, 1);
    check("R1 pri no overrun at 4", p_ovr, 0);
    pcyc(1, 0, 12'hFFF, 5'd31);
    check("R1 pri overrun on 5th", p_ovr, 1);
    for (int i = 0; i < 4; i++) begin
      pcyc(0, 1, 0, 0);
      check($sformatf("R1 pri result %0d", i), p_res, 12'(100 + i));
      check($sformatf("R1 pri chan %0d", i), p_chan, 5'(i + 8));
    end
    check("R1 pri empty", p_empty, 1);
    pcyc(0, 1, 0, 0);
    check("R1 pri fifth dropped", p_valid, 0);
    check("R10 pri irq", p_irq, 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule